// File: doc/BRIEF.md
# External Memory Bus Sequencer

This block runs the multiplexed external memory bus of a small 8-bit controller core that has a 16-bit address space. Time is divided into bus cycles of six clocks, with phases 0 to 5. In each cycle the sequencer either does nothing, hands a code fetch to on-chip program memory, or runs an external transfer. An external transfer puts the low address byte, and then the data, on one shared 8-bit port. The high address byte goes on a second port. An address latch strobe marks the moment when an external latch should capture the low byte. A program-store strobe reads code, and separate strobes read and write data.

The core raises `fetch_req` or `data_req` and holds the address, direction and write data until the matching acknowledge. Requests are taken at the clock edge that ends phase 5. A data request wins over a fetch. Each fetch is routed by the `int_code_en` pin and a 4 KB internal code boundary. An external data access occupies two bus cycles, and the latch strobe is left out of the second cycle. The strobe therefore keeps its one-in-six cadence except for exactly one missing pulse per data access. The shared port is open-drain: when `ad_oe` is low the port is released and floats.

State machine (`xmem_seq_fsm`), states and transitions. All transitions happen at the end of phase 5, and a synchronous reset returns the machine to ST_IDLE at phase 0.
- ST_IDLE: no transfer. It goes to ST_DATA_A on a data request. On a fetch request it goes to ST_FETCH_EXT or ST_FETCH_INT, depending on the routing decision. Otherwise it stays in ST_IDLE.
- ST_FETCH_INT: an internal fetch. It makes the same request-driven choice as ST_IDLE.
- ST_FETCH_EXT: an external fetch. It makes the same request-driven choice as ST_IDLE.
- ST_DATA_A: the first cycle of a data access, covering the address and the strobe start. It always goes to ST_DATA_B and accepts no request.
- ST_DATA_B: the second cycle of a data access, with no latch strobe. It makes the same request-driven choice as ST_IDLE.

Top module: `xmem_bus_seq`

## Requirements
- R1: `ale` is high in phases 0 and 1 and low in phases 2 to 5 of every bus cycle except the second cycle of a data access. Consecutive rising edges of `ale` are therefore 6 clocks apart, or 12 clocks apart across one data access.
- R2: An external data access lasts 12 clocks (two bus cycles) and shows exactly one `ale` pulse, in its first two clocks. The pulse of the second cycle is omitted.
- R3: With `int_code_en` low, every fetch address from 0x0000 to 0xFFFF goes external. With `int_code_en` high, addresses up to and including 0x0FFF are internal and addresses from 0x1000 upward are external. During an internal fetch `route_int` is high for all six phases, `psen_n` stays high, `ad_oe` stays low and `rdata_valid` is not pulsed.
- R4: In an external cycle, `ad_oe` is 1 and `ad_out` carries address bits 7:0 in phases 0 to 2. This holds the byte for one clock after `ale` falls. `addr_hi` carries address bits 15:8 throughout the transfer.
- R5: In an external fetch, `psen_n` is low in phases 3 and 4 only, and the port is released (`ad_oe`=0) in phases 3 to 5. `ad_in` is captured at the end of phase 4 and appears on `rdata`, with `rdata_valid` high for the single clock of phase 5.
- R6: In a data read, `rd_n` is low from phase 3 of the first cycle through phase 4 of the second cycle, and the port is released over that span. `ad_in` is captured at the end of phase 4 of the second cycle and returned with `rdata_valid` in its phase 5. `psen_n` stays high throughout.
- R7: In a data write, `wr_n` is low over the same span as `rd_n` in R6. `ad_oe` is 1 for all 12 clocks, and `ad_out` carries the write data from phase 3 of the first cycle to the end of the second. `psen_n` and `rd_n` stay high.
- R8: `data_ack` or `fetch_ack` is high only in phase 5 of a cycle that is not the first cycle of a data access. It is high only while the matching request is high. When both requests are high, only `data_ack` is given and a data access follows.
- R9: With no request, a bus cycle still pulses `ale` as in R1, keeps `psen_n`, `rd_n` and `wr_n` high, and keeps `ad_oe` low.
- R10: While `rst` is high, `ale` is 0, all three read/write strobes are 1 and `ad_oe` is 0, even in the middle of a transfer. The first clock after `rst` falls is phase 0 of an idle cycle, so `ale` is 1.
- R11: At most one of `psen_n`, `rd_n` and `wr_n` is low in any clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one bus cycle is six clocks |
| rst | input | 1 | Synchronous reset, active high |
| int_code_en | input | 1 | High allows fetches at or below 0x0FFF to use on-chip code memory |
| fetch_req | input | 1 | Code fetch request, held until `fetch_ack` |
| fetch_addr | input | 16 | Code fetch address |
| data_req | input | 1 | External data access request, held until `data_ack` |
| data_we | input | 1 | 1 for a write, 0 for a read |
| data_addr | input | 16 | External data address |
| data_wdata | input | 8 | Write data |
| fetch_ack | output | 1 | Fetch request taken at the coming edge |
| data_ack | output | 1 | Data request taken at the coming edge |
| route_int | output | 1 | Current cycle is an internal fetch |
| rdata | output | 8 | Byte returned by the last external read or fetch |
| rdata_valid | output | 1 | One-clock pulse: `rdata` is new |
| ad_in | input | 8 | Pin values of the shared address/data port |
| ad_out | output | 8 | Value driven on the shared port |
| ad_oe | output | 1 | Shared port drive enable; 0 releases the pins |
| addr_hi | output | 8 | High address byte port |
| ale | output | 1 | Address latch strobe, active high |
| psen_n | output | 1 | Program-store read strobe, active low |
| rd_n | output | 1 | Data read strobe, active low |
| wr_n | output | 1 | Data write strobe, active low |

## Verification
Fetches are tried at 0x0ABC, at the boundary addresses 0x0FFF and 0x1000, at 0xFFFF, and at a low address with `int_code_en` low. Together these separate a correct boundary comparison from an off-by-one error, and separate the pin override from the address test. A read and a write with different address bytes show whether the latch pulse is dropped in the right cycle and whether the port direction is right over the whole strobe span. A request collision while data is pending shows whether data priority holds, and whether the machine refuses requests mid-access. A reset applied in the middle of a write shows that the strobes are cut at once and that the cycle restarts at phase 0.

// File: rtl/xmem_pkg.sv
package xmem_pkg;

    typedef enum logic [2:0] {
        ST_IDLE      = 3'd0,
        ST_FETCH_INT = 3'd1,
        ST_FETCH_EXT = 3'd2,
        ST_DATA_A    = 3'd3,
        ST_DATA_B    = 3'd4
    } bus_state_t;

endpackage

// File: rtl/xmem_phase_ctr.sv
module xmem_phase_ctr #(
    parameter int CYC_LEN = 6,
    localparam int PH_W   = $clog2(CYC_LEN)
) (
    input  logic            clk,
    input  logic            rst,
    output logic [PH_W-1:0] phase,
    output logic            last
);

    localparam logic [PH_W-1:0] P_LAST = PH_W'(CYC_LEN - 1);

    assign last = (phase == P_LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= '0;
        end else if (last) begin
            phase <= '0;
        end else begin
            phase <= phase + 1'b1;
        end
    end

    // R1: the phase never leaves its range
    a_r1_phase_range: assert property (@(posedge clk) disable iff (rst)
        phase <= P_LAST);

endmodule

// File: rtl/xmem_route.sv
module xmem_route #(
    parameter int              ADDR_W  = 16,
    parameter logic [ADDR_W-1:0] INT_TOP = 'h0FFF
) (
    input  logic              int_code_en,
    input  logic [ADDR_W-1:0] addr,
    output logic              go_ext
);

    always_comb begin
        go_ext = !int_code_en || (addr > INT_TOP);
    end

endmodule

// File: rtl/xmem_seq_fsm.sv
module xmem_seq_fsm
    import xmem_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int DATA_W  = 8,
    parameter int CYC_LEN = 6,
    parameter int ALE_LEN = 2,
    localparam int PH_W   = $clog2(CYC_LEN)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [PH_W-1:0]          phase,
    input  logic                     last,
    input  logic                     fetch_req,
    input  logic [ADDR_W-1:0]        fetch_addr,
    input  logic                     fetch_ext,
    input  logic                     data_req,
    input  logic                     data_we,
    input  logic [ADDR_W-1:0]        data_addr,
    input  logic [DATA_W-1:0]        data_wdata,
    input  logic [DATA_W-1:0]        ad_in,
    output logic                     fetch_ack,
    output logic                     data_ack,
    output logic                     route_int,
    output logic [DATA_W-1:0]        rdata,
    output logic                     rdata_valid,
    output logic [DATA_W-1:0]        ad_out,
    output logic                     ad_oe,
    output logic [ADDR_W-DATA_W-1:0] addr_hi,
    output logic                     ale,
    output logic                     psen_n,
    output logic                     rd_n,
    output logic                     wr_n
);

    localparam logic [PH_W-1:0] P_ALE_END   = PH_W'(ALE_LEN);
    localparam logic [PH_W-1:0] P_STB_FIRST = PH_W'(ALE_LEN + 1);
    localparam logic [PH_W-1:0] P_STB_LAST  = PH_W'(CYC_LEN - 2);

    bus_state_t          state_q;
    bus_state_t          state_d;
    logic [ADDR_W-1:0]   addr_q;
    logic                we_q;
    logic [DATA_W-1:0]   wdata_q;
    logic [DATA_W-1:0]   rdata_q;
    logic                rvalid_q;
    logic                accept;
    logic                ale_win;
    logic                addr_win;
    logic                stb_win;
    logic                tail_win;

    // Request acceptance: only at the end of a cycle that may finish
    assign accept    = last && (state_q != ST_DATA_A) && !rst;
    assign data_ack  = accept && data_req;
    assign fetch_ack = accept && fetch_req && !data_req;

    // Next-state choice
    always_comb begin
        state_d = state_q;
        if (last) begin
            unique case (state_q)
                ST_DATA_A: state_d = ST_DATA_B;
                ST_IDLE, ST_FETCH_INT, ST_FETCH_EXT, ST_DATA_B: begin
                    if (data_req) begin
                        state_d = ST_DATA_A;
                    end else if (fetch_req) begin
                        state_d = fetch_ext ? ST_FETCH_EXT : ST_FETCH_INT;
                    end else begin
                        state_d = ST_IDLE;
                    end
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // State register and request latch
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            addr_q  <= '0;
            we_q    <= 1'b0;
            wdata_q <= '0;
        end else begin
            state_q <= state_d;
            if (data_ack) begin
                addr_q  <= data_addr;
                we_q    <= data_we;
                wdata_q <= data_wdata;
            end else if (fetch_ack) begin
                addr_q  <= fetch_addr;
                we_q    <= 1'b0;
            end
        end
    end

    // Read capture
    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_q  <= '0;
            rvalid_q <= 1'b0;
        end else begin
            rvalid_q <= 1'b0;
            if ((phase == P_STB_LAST) &&
                ((state_q == ST_FETCH_EXT) || ((state_q == ST_DATA_B) && !we_q))) begin
                rdata_q  <= ad_in;
                rvalid_q <= 1'b1;
            end
        end
    end

    assign rdata       = rdata_q;
    assign rdata_valid = rvalid_q;
    assign addr_hi     = addr_q[ADDR_W-1:DATA_W];

    assign ale_win  = (phase <  P_ALE_END);
    assign addr_win = (phase <= P_ALE_END);
    assign stb_win  = (phase >= P_STB_FIRST) && (phase <= P_STB_LAST);
    assign tail_win = (phase >= P_STB_FIRST);

    // Pin outputs
    always_comb begin
        ale       = 1'b0;
        psen_n    = 1'b1;
        rd_n      = 1'b1;
        wr_n      = 1'b1;
        ad_oe     = 1'b0;
        ad_out    = '0;
        route_int = 1'b0;
        if (!rst) begin
            unique case (state_q)
                ST_IDLE: begin
                    ale = ale_win;
                end
                ST_FETCH_INT: begin
                    ale       = ale_win;
                    route_int = 1'b1;
                end
                ST_FETCH_EXT: begin
                    ale = ale_win;
                    if (addr_win) begin
                        ad_oe  = 1'b1;
                        ad_out = addr_q[DATA_W-1:0];
                    end
                    psen_n = !stb_win;
                end
                ST_DATA_A: begin
                    ale = ale_win;
                    if (addr_win) begin
                        ad_oe  = 1'b1;
                        ad_out = addr_q[DATA_W-1:0];
                    end else if (tail_win) begin
                        if (we_q) begin
                            wr_n   = 1'b0;
                            ad_oe  = 1'b1;
                            ad_out = wdata_q;
                        end else begin
                            rd_n = 1'b0;
                        end
                    end
                end
                ST_DATA_B: begin
                    if (we_q) begin
                        wr_n   = !(phase <= P_STB_LAST);
                        ad_oe  = 1'b1;
                        ad_out = wdata_q;
                    end else begin
                        rd_n = !(phase <= P_STB_LAST);
                    end
                end
                default: begin
                    ale = 1'b0;
                end
            endcase
        end
    end

    // R11: one strobe at a time
    a_r11_one_strobe: assert property (@(posedge clk) disable iff (rst)
        $countones({!psen_n, !rd_n, !wr_n}) <= 1);

    // R7: the port drives while the write strobe is low
    a_r7_write_drives: assert property (@(posedge clk) disable iff (rst)
        !wr_n |-> ad_oe);

    // R6: the port is released while the read strobe is low
    a_r6_read_released: assert property (@(posedge clk) disable iff (rst)
        !rd_n |-> !ad_oe);

    // R4: the low address byte holds across the latch strobe's falling edge
    a_r4_addr_hold: assert property (@(posedge clk) disable iff (rst)
        ($fell(ale) && $past(ad_oe)) |-> (ad_oe && $stable(ad_out)));

    // R3: an internal fetch touches no external pin
    a_r3_int_quiet: assert property (@(posedge clk) disable iff (rst)
        route_int |-> (psen_n && !ad_oe));

    // R5: returned data appears only in the last phase
    a_r5_valid_phase: assert property (@(posedge clk) disable iff (rst)
        rdata_valid |-> last);

    // R8: never two acknowledges together
    a_r8_single_ack: assert property (@(posedge clk) disable iff (rst)
        !(fetch_ack && data_ack));

endmodule

// File: rtl/xmem_bus_seq.sv
module xmem_bus_seq #(
    parameter int ADDR_W  = 16,
    parameter int DATA_W  = 8,
    parameter int CYC_LEN = 6,
    parameter int ALE_LEN = 2,
    parameter logic [ADDR_W-1:0] INT_TOP = 'h0FFF
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     int_code_en,
    input  logic                     fetch_req,
    input  logic [ADDR_W-1:0]        fetch_addr,
    input  logic                     data_req,
    input  logic                     data_we,
    input  logic [ADDR_W-1:0]        data_addr,
    input  logic [DATA_W-1:0]        data_wdata,
    output logic                     fetch_ack,
    output logic                     data_ack,
    output logic                     route_int,
    output logic [DATA_W-1:0]        rdata,
    output logic                     rdata_valid,
    input  logic [DATA_W-1:0]        ad_in,
    output logic [DATA_W-1:0]        ad_out,
    output logic                     ad_oe,
    output logic [ADDR_W-DATA_W-1:0] addr_hi,
    output logic                     ale,
    output logic                     psen_n,
    output logic                     rd_n,
    output logic                     wr_n
);

    localparam int PH_W  = $clog2(CYC_LEN);
    localparam int GAP_W = $clog2(2 * CYC_LEN + 2);

    logic [PH_W-1:0] phase;
    logic            last;
    logic            fetch_ext;

    xmem_phase_ctr #(.CYC_LEN(CYC_LEN)) u_phase (
        .clk   (clk),
        .rst   (rst),
        .phase (phase),
        .last  (last)
    );

    xmem_route #(.ADDR_W(ADDR_W), .INT_TOP(INT_TOP)) u_route (
        .int_code_en (int_code_en),
        .addr        (fetch_addr),
        .go_ext      (fetch_ext)
    );

    xmem_seq_fsm #(
        .ADDR_W  (ADDR_W),
        .DATA_W  (DATA_W),
        .CYC_LEN (CYC_LEN),
        .ALE_LEN (ALE_LEN)
    ) u_fsm (
        .clk         (clk),
        .rst         (rst),
        .phase       (phase),
        .last        (last),
        .fetch_req   (fetch_req),
        .fetch_addr  (fetch_addr),
        .fetch_ext   (fetch_ext),
        .data_req    (data_req),
        .data_we     (data_we),
        .data_addr   (data_addr),
        .data_wdata  (data_wdata),
        .ad_in       (ad_in),
        .fetch_ack   (fetch_ack),
        .data_ack    (data_ack),
        .route_int   (route_int),
        .rdata       (rdata),
        .rdata_valid (rdata_valid),
        .ad_out      (ad_out),
        .ad_oe       (ad_oe),
        .addr_hi     (addr_hi),
        .ale         (ale),
        .psen_n      (psen_n),
        .rd_n        (rd_n),
        .wr_n        (wr_n)
    );

    // Latch-strobe spacing monitor
    logic             ale_d;
    logic             seen_rise;
    logic [GAP_W-1:0] gap;
    logic             ale_rise;

    assign ale_rise = ale && !ale_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            ale_d     <= 1'b0;
            seen_rise <= 1'b0;
            gap       <= '0;
        end else begin
            ale_d <= ale;
            if (ale_rise) begin
                seen_rise <= 1'b1;
                gap       <= GAP_W'(1);
            end else if (gap != {GAP_W{1'b1}}) begin
                gap <= gap + 1'b1;
            end
        end
    end

    // R1 and R2: rising edges 6 clocks apart, or 12 across a data access
    a_r2_ale_gap: assert property (@(posedge clk) disable iff (rst)
        (seen_rise && ale_rise) |-> ((gap == GAP_W'(CYC_LEN)) || (gap == GAP_W'(2 * CYC_LEN))));

endmodule

// File: tb/xmem_bus_seq_tb.sv
`timescale 1ns/1ps
module xmem_bus_seq_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        int_code_en = 1'b1;
    logic        fetch_req = 1'b0;
    logic [15:0] fetch_addr = '0;
    logic        data_req = 1'b0;
    logic        data_we = 1'b0;
    logic [15:0] data_addr = '0;
    logic [7:0]  data_wdata = '0;
    logic [7:0]  ad_in = '0;
    logic        fetch_ack, data_ack, route_int, rdata_valid, ad_oe, ale, psen_n, rd_n, wr_n;
    logic [7:0]  rdata, ad_out, addr_hi;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic [11:0] c_ale, c_psen, c_rd, c_wr, c_oe, c_val, c_rint;
    logic [7:0]  c_ad [12];
    logic [7:0]  c_hi [12];
    logic [7:0]  c_rdata [12];

    always #2.5 clk = ~clk;

    xmem_bus_seq u_dut (
        .clk (clk), .rst (rst), .int_code_en (int_code_en),
        .fetch_req (fetch_req), .fetch_addr (fetch_addr),
        .data_req (data_req), .data_we (data_we), .data_addr (data_addr),
        .data_wdata (data_wdata), .fetch_ack (fetch_ack), .data_ack (data_ack),
        .route_int (route_int), .rdata (rdata), .rdata_valid (rdata_valid),
        .ad_in (ad_in), .ad_out (ad_out), .ad_oe (ad_oe), .addr_hi (addr_hi),
        .ale (ale), .psen_n (psen_n), .rd_n (rd_n), .wr_n (wr_n)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic capture(input int n);
        for (int i = 0; i < n; i++) begin
            c_ale[i] = ale;  c_psen[i] = psen_n; c_rd[i] = rd_n; c_wr[i] = wr_n;
            c_oe[i]  = ad_oe; c_val[i] = rdata_valid; c_rint[i] = route_int;
            c_ad[i]  = ad_out; c_hi[i] = addr_hi; c_rdata[i] = rdata;
            step(1);
        end
    endtask

    // R10: reset state and restart at phase 0
    task automatic t_reset;
        rst = 1'b1;
        step(3);
        chk(ale == 1'b0, "R10 ale in reset", ale, 0);
        chk({psen_n, rd_n, wr_n} == 3'b111, "R10 strobes in reset", {psen_n, rd_n, wr_n}, 7);
        chk(ad_oe == 1'b0, "R10 port released in reset", ad_oe, 0);
        rst = 1'b0;
        #0.5;
        chk(ale == 1'b1, "R10 phase 0 after release", ale, 1);
    endtask

    // R9 and R1: idle cycle
    task automatic t_idle;
        capture(6);
        chk(c_ale[5:0] == 6'b000011, "R1 ale pattern idle", c_ale[5:0], 6'b000011);
        chk(c_psen[5:0] == 6'h3F && c_rd[5:0] == 6'h3F && c_wr[5:0] == 6'h3F,
            "R9 strobes high idle", {c_psen[5:0], c_rd[5:0], c_wr[5:0]}, 18'h3FFFF);
        chk(c_oe[5:0] == 6'h00, "R9 port released idle", c_oe[5:0], 0);
    endtask

    // R3, R4, R5: one fetch
    task automatic t_fetch(input logic [15:0] addr, input logic en,
                           input logic [7:0] din, input bit exp_ext);
        int_code_en = en;
        fetch_req   = 1'b1;
        fetch_addr  = addr;
        step(5);
        chk(fetch_ack == 1'b1 && data_ack == 1'b0, "R8 fetch ack", {fetch_ack, data_ack}, 2);
        step(1);
        fetch_req = 1'b0;
        ad_in     = din;
        capture(6);
        chk(c_ale[5:0] == 6'b000011, "R1 ale pattern fetch", c_ale[5:0], 6'b000011);
        if (exp_ext) begin
            chk(c_rint[5:0] == 6'h00, "R3 external route", c_rint[5:0], 0);
            chk(c_oe[5:0] == 6'b000111, "R4/R5 port enable", c_oe[5:0], 6'b000111);
            for (int i = 0; i < 3; i++)
                chk(c_ad[i] == addr[7:0], "R4 low address", c_ad[i], addr[7:0]);
            for (int i = 0; i < 6; i++)
                chk(c_hi[i] == addr[15:8], "R4 high address", c_hi[i], addr[15:8]);
            chk(c_psen[5:0] == 6'b100111, "R5 psen window", c_psen[5:0], 6'b100111);
            chk(c_val[5:0] == 6'b100000, "R5 valid phase", c_val[5:0], 6'b100000);
            chk(c_rdata[5] == din, "R5 fetched byte", c_rdata[5], din);
        end else begin
            chk(c_rint[5:0] == 6'h3F, "R3 internal route", c_rint[5:0], 6'h3F);
            chk(c_psen[5:0] == 6'h3F, "R3 psen idle internal", c_psen[5:0], 6'h3F);
            chk(c_oe[5:0] == 6'h00, "R3 port released internal", c_oe[5:0], 0);
            chk(c_val[5:0] == 6'h00, "R3 no valid internal", c_val[5:0], 0);
        end
    endtask

    // R2, R6, R7: one data access
    task automatic t_data(input logic [15:0] addr, input logic we,
                          input logic [7:0] wd, input logic [7:0] din);
        data_req   = 1'b1;
        data_we    = we;
        data_addr  = addr;
        data_wdata = wd;
        step(5);
        chk(data_ack == 1'b1 && fetch_ack == 1'b0, "R8 data ack", {data_ack, fetch_ack}, 2);
        step(1);
        data_req = 1'b0;
        ad_in    = din;
        capture(12);
        chk($countones(c_ale) == 2 && c_ale[1:0] == 2'b11, "R2 single ale pulse", c_ale, 12'h003);
        chk(c_psen == 12'hFFF, "R6/R7 psen high in data", c_psen, 12'hFFF);
        for (int i = 0; i < 3; i++)
            chk(c_oe[i] && c_ad[i] == addr[7:0], "R4 data low address", c_ad[i], addr[7:0]);
        for (int i = 0; i < 12; i++)
            chk(c_hi[i] == addr[15:8], "R4 data high address", c_hi[i], addr[15:8]);
        if (we) begin
            chk(c_wr == 12'b100000000111, "R7 wr window", c_wr, 12'b100000000111);
            chk(c_rd == 12'hFFF, "R7 rd high", c_rd, 12'hFFF);
            chk(c_oe == 12'hFFF, "R7 drive all clocks", c_oe, 12'hFFF);
            for (int i = 3; i < 12; i++)
                chk(c_ad[i] == wd, "R7 write data", c_ad[i], wd);
            chk(c_val == 12'h000, "R7 no valid on write", c_val, 0);
        end else begin
            chk(c_rd == 12'b100000000111, "R6 rd window", c_rd, 12'b100000000111);
            chk(c_wr == 12'hFFF, "R6 wr high", c_wr, 12'hFFF);
            chk(c_oe[11:3] == 9'h000, "R6 port released", c_oe[11:3], 0);
            chk(c_val == 12'b100000000000, "R6 valid phase", c_val, 12'h800);
            chk(c_rdata[11] == din, "R6 read byte", c_rdata[11], din);
        end
    endtask

    // R8: data beats fetch, no acceptance inside a data access
    task automatic t_priority;
        int_code_en = 1'b1;
        fetch_req = 1'b1; fetch_addr = 16'h0200;
        data_req = 1'b1; data_we = 1'b0; data_addr = 16'h7766;
        step(5);
        chk(data_ack == 1'b1 && fetch_ack == 1'b0, "R8 data wins", {data_ack, fetch_ack}, 2);
        step(1);
        for (int i = 0; i < 6; i++) begin
            if (i == 3) chk(rd_n == 1'b0 && route_int == 1'b0, "R8 data cycle runs", rd_n, 0);
            if (i == 5) chk(data_ack == 1'b0 && fetch_ack == 1'b0, "R8 no ack mid access",
                            {data_ack, fetch_ack}, 0);
            step(1);
        end
        fetch_req = 1'b0; data_req = 1'b0;
        step(6);
    endtask

    // R10: reset in the middle of a write
    task automatic t_mid_reset;
        data_req = 1'b1; data_we = 1'b1; data_addr = 16'h1234; data_wdata = 8'h99;
        step(6);
        data_req = 1'b0;
        step(4);
        chk(wr_n == 1'b0, "R10 write in progress", wr_n, 0);
        rst = 1'b1;
        #0.5;
        chk(wr_n == 1'b1 && ad_oe == 1'b0 && ale == 1'b0, "R10 cut mid write",
            {wr_n, ad_oe, ale}, 4);
        step(1);
        rst = 1'b0;
        #0.5;
        chk(ale == 1'b1, "R10 restart phase 0", ale, 1);
        #0.5;
        capture(6);
        chk(c_wr[5:0] == 6'h3F && c_oe[5:0] == 6'h00, "R10 idle after reset",
            {c_wr[5:0], c_oe[5:0]}, 12'hFC0);
    endtask

    initial begin
        #1;
        t_reset();
        step(1);
        #0;
        // align: one full idle cycle starting at phase 1 consumed, then sync to phase 0
        step(5);
        t_idle();
        t_fetch(16'h0ABC, 1'b1, 8'h11, 1'b0);
        t_fetch(16'h0FFF, 1'b1, 8'h22, 1'b0);
        t_fetch(16'h1000, 1'b1, 8'hA5, 1'b1);
        t_fetch(16'h0123, 1'b0, 8'h3C, 1'b1);
        t_fetch(16'hFFFF, 1'b1, 8'hC7, 1'b1);
        t_data(16'h5A3C, 1'b0, 8'h00, 8'h6E);
        t_data(16'hC381, 1'b1, 8'hB4, 8'h00);
        t_priority();
        t_idle();
        t_mid_reset();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            done = 1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule